// File: doc/BRIEF.md
# Serial Command and Diagnostic Port for an Eight-Channel Driver

This block is the slave side of a four-wire synchronous serial link that controls an eight-channel output driver. An external master pulls the active-low select line low, toggles the serial clock and presents command bits on the data input. The block returns the sensed level of each channel output on the data output. When select rises again, the newly received command drives all channel enables together. The block does no analog sensing. Each channel's output level arrives as a digital status bit.

Select, serial clock and data input are asynchronous to the block. Each goes through a two-flop synchronizer clocked by a fast system clock, and edge detection happens in that clock domain. The system clock must run at least eight times faster than the serial clock. The output enable takes the place of the tri-state control for the data-output pad. A one-cycle pulse marks each frame whose clock count is a nonzero multiple of the channel count. Such a frame is a correct transfer, and a supervisor can use the pulse to clear a latched thermal fault.

Top module: `sdi_port`

## Requirements
- R1: While reset is asserted and directly after it, `chanEn` is all zeros, `sdoEn` is 0 and `frameOk` is 0.
- R2: `sdoEn` is 1 only inside a frame, that is after select has been seen low and before it has been seen high again. Between frames it is 0.
- R3: The channel status bits are captured when select falls. A change of `diagIn` after that capture does not alter the bits shifted out in that frame.
- R4: `sdo` presents channel 1 status (`diagIn[0]`) first and moves to the next channel on each rising serial clock, ending with channel 8 (`diagIn[7]`).
- R5: `sdin` is sampled on rising serial clock edges, channel 1 first. After an eight-clock frame, `chanEn[k]` equals the bit received on clock k+1.
- R6: `chanEn` does not change during a frame. All eight bits take their new values together, after select rises.
- R7: In a frame of 16 or 24 clocks, only the last eight bits received set `chanEn`. The earlier bits are discarded.
- R8: `frameOk` is a one-cycle pulse issued at the end of a frame whose clock count is a nonzero multiple of 8. No other frame produces it.
- R9: A frame whose clock count is not a multiple of 8 still loads the input shift register into `chanEn`, with the received bits entering at the channel 8 end. A frame with no clocks leaves `chanEn` unchanged.
- R10: A select edge at the pins shows up at the outputs on the third rising system clock edge after it: two synchronizer stages, then the registers that act on the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low write/select from the master |
| sclk | input | 1 | Serial clock, idles high |
| sdin | input | 1 | Serial command data from the master |
| diagIn | input | 8 | Sensed output level per channel, bit 0 = channel 1 |
| sdo | output | 1 | Serial status data to the master |
| sdoEn | output | 1 | Drive enable for the data-output pad (0 = high impedance) |
| chanEn | output | 8 | Channel enables, bit 0 = channel 1 |
| frameOk | output | 1 | One-cycle pulse marking a correctly sized frame |

## Verification
Every pin change reaches the outputs on the third rising system edge after it. The bench confirms this with one directed test, which samples `sdoEn` just after the second edge (still low) and just after the third (high). Everywhere else the bench holds each serial level for eight system cycles and reads the outputs one time unit after a system edge. By then each shift, snapshot and command update has settled, and the next pin change has not yet reached the registers. The `frameOk` pulse lasts exactly one cycle, so a falling-edge monitor counts it, and the bench compares the count from before a frame with the count after it.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  // control-to-datapath strobes, all one system cycle wide
  typedef struct packed {
    logic loadDiag;  // capture channel status into the output shifter
    logic shift;     // one serial bit in, one serial bit out
    logic commit;    // transfer input shifter to the command register
  } sdiStrobe_t;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int Width = 1,
  parameter int Stages = 2,
  parameter logic [Width-1:0] ResetVal = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] d,
  output logic [Width-1:0] q
);
  logic [Width-1:0] stage [Stages];

  for (genvar g = 0; g < Stages; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= ResetVal;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g - 1];
    end
  end

  assign q = stage[Stages-1];
endmodule

// File: rtl/sdi_ctrl.sv
module sdi_ctrl
  import sdi_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selS,
  input  logic       sclkS,
  output sdiStrobe_t strb,
  output logic       active,
  output logic       frameOk
);
  localparam int CntW = (NumChan > 1) ? $clog2(NumChan) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(NumChan - 1);

  logic selPrev, sclkPrev, anyClk;
  logic [CntW-1:0] bitCnt;
  logic selFall, selRise, sclkRise;

  assign selFall  = selPrev & ~selS;
  assign selRise  = ~selPrev & selS;
  assign sclkRise = ~sclkPrev & sclkS;

  always_comb begin
    strb.loadDiag = selFall;
    strb.shift    = sclkRise & active & ~selS;
    strb.commit   = selRise & active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b1;
      sclkPrev <= 1'b1;
      active   <= 1'b0;
      anyClk   <= 1'b0;
      bitCnt   <= '0;
      frameOk  <= 1'b0;
    end else begin
      selPrev  <= selS;
      sclkPrev <= sclkS;
      frameOk  <= 1'b0;
      if (selFall) begin
        active <= 1'b1;
        anyClk <= 1'b0;
        bitCnt <= '0;
      end else if (strb.commit) begin
        active  <= 1'b0;
        frameOk <= anyClk & (bitCnt == '0);
      end else if (strb.shift) begin
        anyClk <= 1'b1;
        bitCnt <= (bitCnt == LastCnt) ? '0 : bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdi_datapath.sv
module sdi_datapath
  import sdi_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  sdiStrobe_t         strb,
  input  logic               dinS,
  input  logic [NumChan-1:0] diagIn,
  output logic [NumChan-1:0] chanEn,
  output logic               sdoBit
);
  logic [NumChan-1:0] inShift, outShift, cmdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      cmdReg   <= '0;
    end else begin
      if (strb.loadDiag) outShift <= diagIn;
      else if (strb.shift) outShift <= {1'b0, outShift[NumChan-1:1]};
      if (strb.shift) inShift <= {dinS, inShift[NumChan-1:1]};
      if (strb.commit) cmdReg <= inShift;
    end
  end

  assign chanEn = cmdReg;
  assign sdoBit = outShift[0];
endmodule

// File: rtl/sdi_port.sv
module sdi_port
  import sdi_pkg::*;
#(
  parameter int NumChan = 8,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selN,
  input  logic               sclk,
  input  logic               sdin,
  input  logic [NumChan-1:0] diagIn,
  output logic               sdo,
  output logic               sdoEn,
  output logic [NumChan-1:0] chanEn,
  output logic               frameOk
);
  logic [2:0] pinSync;
  sdiStrobe_t strb;
  logic active, sdoBit;

  sdi_sync #(.Width(3), .Stages(SyncStages), .ResetVal(3'b011)) uSync (
    .clk(clk), .rstN(rstN), .d({sdin, sclk, selN}), .q(pinSync)
  );

  sdi_ctrl #(.NumChan(NumChan)) uCtrl (
    .clk(clk), .rstN(rstN), .selS(pinSync[0]), .sclkS(pinSync[1]),
    .strb(strb), .active(active), .frameOk(frameOk)
  );

  sdi_datapath #(.NumChan(NumChan)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(pinSync[2]),
    .diagIn(diagIn), .chanEn(chanEn), .sdoBit(sdoBit)
  );

  assign sdoEn = active;
  assign sdo   = active & sdoBit;
endmodule

// File: rtl/sdi_port_chk.sv
module sdi_port_chk #(
  parameter int NumChan = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NumChan-1:0] chanEn,
  input logic               frameOk,
  input logic               sdoEn,
  input logic               loadDiag,
  input logic               commit
);
  // R6
  cmd_at_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn != $past(chanEn)) |-> $past(commit));

  // R8
  ok_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |-> $past(commit));

  // R8
  ok_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |=> !frameOk);

  // R2
  drive_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> $past(loadDiag));

  // R2
  release_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !sdoEn);
endmodule

bind sdi_port sdi_port_chk #(.NumChan(NumChan)) uChk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .frameOk(frameOk),
  .sdoEn(sdoEn), .loadDiag(strb.loadDiag), .commit(strb.commit)
);

// File: tb/sdi_port_test.sv
`timescale 1ns/1ps
module sdi_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [7:0] diagIn = 8'h00;
  logic sdo, sdoEn, frameOk;
  logic [7:0] chanEn;
  int total = 0, fails = 0, okSeen = 0;
  bit done = 0;

  localparam int Half = 8;
  // {clocks, din bits (bit i on clock i+1), diag, expected chanEn, expected frameOk}
  localparam logic [48:0] Vecs [7] = '{
    {8'd8,  24'h0000A5, 8'h3C, 8'hA5, 1'b1},
    {8'd16, 24'h005AFF, 8'h81, 8'h5A, 1'b1},
    {8'd8,  24'h000000, 8'hFF, 8'h00, 1'b1},
    {8'd4,  24'h00000F, 8'h12, 8'hF0, 1'b0},
    {8'd12, 24'h000C33, 8'h77, 8'hC3, 1'b0},
    {8'd0,  24'h000000, 8'h00, 8'hC3, 1'b0},
    {8'd24, 24'h961234, 8'hE7, 8'h96, 1'b1}
  };

  always #2.5 clk = ~clk;

  sdi_port uut (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdin(sdin),
    .diagIn(diagIn), .sdo(sdo), .sdoEn(sdoEn), .chanEn(chanEn), .frameOk(frameOk)
  );

  always @(negedge clk) if (frameOk === 1'b1) okSeen++;

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input int n, input logic [23:0] din, input logic [7:0] diag,
                          input logic [7:0] expCmd, input logic expOk);
    logic [7:0] got = 8'h00;
    logic [7:0] prevCmd = chanEn;
    logic [7:0] mask = (n >= 8) ? 8'hFF : 8'((1 << n) - 1);
    int okBefore = okSeen;
    diagIn = diag;
    selN = 1'b0;
    waitCyc(Half);
    diagIn = ~diag;  // after the snapshot: must not reach sdo (R3)
    check("R2 sdoEn inside frame", 32'(sdoEn), 32'd1);
    for (int i = 0; i < n; i++) begin
      if (i < 8) got[i] = sdo;
      sclk = 1'b0;
      sdin = din[i];
      waitCyc(Half);
      sclk = 1'b1;
      waitCyc(Half);
    end
    check("R3 R4 sdo bit order", 32'(got & mask), 32'(diag & mask));
    check("R6 chanEn held during frame", 32'(chanEn), 32'(prevCmd));
    selN = 1'b1;
    waitCyc(Half);
    check("R5 R7 R9 chanEn after frame", 32'(chanEn), 32'(expCmd));
    check("R8 frameOk pulses", 32'(okSeen - okBefore), 32'(expOk));
    check("R2 sdoEn between frames", 32'(sdoEn), 32'd0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    waitCyc(4);
    check("R1 chanEn in reset", 32'(chanEn), 32'd0);
    check("R1 sdoEn in reset", 32'(sdoEn), 32'd0);
    rstN = 1'b1;
    waitCyc(4);
    check("R1 chanEn after reset", 32'(chanEn), 32'd0);
    check("R1 frameOk after reset", 32'(frameOk), 32'd0);
    check("R1 sdoEn after reset", 32'(sdoEn), 32'd0);

    // R10: exact latency of a select edge
    selN = 1'b0;
    waitCyc(2);
    check("R10 sdoEn after two edges", 32'(sdoEn), 32'd0);
    waitCyc(1);
    check("R10 sdoEn after three edges", 32'(sdoEn), 32'd1);
    selN = 1'b1;
    waitCyc(Half);
    check("R9 empty frame keeps chanEn", 32'(chanEn), 32'd0);
    check("R8 empty frame no pulse", 32'(okSeen), 32'd0);

    foreach (Vecs[v]) begin
      runFrame(int'(Vecs[v][48:41]), Vecs[v][40:17], Vecs[v][16:9],
               Vecs[v][8:1], Vecs[v][0]);
      waitCyc(Half);
    end
    finishRun();
  end
endmodule